// File: doc/BRIEF.md
# Motor Driver Fault Response Controller

This block sits between the protection monitors of a half-bridge motor driver and its power stage. It takes synchronized flags for supply undervoltage, charge pump undervoltage, overvoltage, overcurrent, per-switch current limit, serial-interface error, configuration memory error, thermal warning and thermal shutdown. For each flag it applies a policy set by mode inputs from the register file.

From those flags it produces a bridge high-impedance enable, a logic-disable signal, an active-low fault pin, a vector of sticky status bits, and per-switch current-limit gating for the high and low sides of every phase. Software acknowledges faults with a single-cycle clear pulse or with a reset pulse from the sleep pin. Each acknowledgement clears only the status bits whose condition is gone.

All outputs are registered, or decoded straight from registers. A flag sampled at one clock edge is reflected on the outputs right after that edge.

Top module: `fault_resp_ctrl`

## Requirements
- R1: If any bit of `uv_i` (main, gate-drive or regulator rail) is high, `hiz_o` and `logic_dis_o` are high after the next edge. Both drop after the first edge at which all rails are good. Status bit 0 (reset) is set, and it never drives `fault_no`.
- R2: Charge pump undervoltage sets `hiz_o`, status bit 1 and the fault pin, and leaves `logic_dis_o` low. `hiz_o` drops after the edge at which the flag is gone.
- R3: Overvoltage with `ovp_mode_i`=0 has no effect on any output. With `ovp_mode_i`=1 it sets `hiz_o`, status bit 2 and the fault pin, and `hiz_o` follows the flag back down.
- R4: With `ocp_mode_i`=00, overcurrent latches `hiz_o`, status bit 3 and the fault pin. They stay latched until a clear is given while `ocp_i` is low.
- R5: With `ocp_mode_i`=01 and a retry count R on `retry_cycles_i`, `hiz_o` is high for exactly R+1 cycles after detection if the flag is gone by then. If the flag is still present, the timer reloads. Status bit 3 stays set until cleared.
- R6: With `ocp_mode_i`=10, overcurrent sets status bit 3 and the fault pin while the bridge stays active. With 11 it has no effect.
- R7: A current-limit flag on a switch sets its gating output (`hs_off_o[p]` or `ls_off_o[p]`) after the next edge. The gating clears only after a rising edge of that same switch's gate input, and the other switches are unaffected.
- R8: A current-limit event sets status bit 4 and the fault pin only when `ilim_rpt_i`=1.
- R9: A serial-interface error is ignored with `spi_mode_i`=0. With 1 it sets status bit 5 and the fault pin without touching `hiz_o`.
- R10: A configuration memory error latches `hiz_o`, status bit 6 and the fault pin. All three release only on a clear given after the flag is gone.
- R11: A thermal warning sets status bit 7 and the fault pin only when `otw_mode_i`=1, with the bridge active. Thermal shutdown always sets `hiz_o`, status bit 8 and the fault pin, and `hiz_o` follows the flag back down.
- R12: Status bits are sticky. A pulse on `clr_flt_i` or `sleep_rst_i` clears exactly those bits whose condition is absent at that edge.
- R13: `fault_no` is low exactly when any of status bits 1 to 8 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| uv_i | input | N_RAIL | Rail undervoltage flags |
| cpuv_i | input | 1 | Charge pump undervoltage flag |
| ovp_i | input | 1 | Overvoltage flag |
| ocp_i | input | 1 | Overcurrent flag |
| ilim_hs_i | input | N_PH | High-side current-limit flags |
| ilim_ls_i | input | N_PH | Low-side current-limit flags |
| gate_hs_i | input | N_PH | High-side gate command inputs |
| gate_ls_i | input | N_PH | Low-side gate command inputs |
| spi_err_i | input | 1 | Serial-interface error flag |
| otp_err_i | input | 1 | Configuration memory read error |
| otw_i | input | 1 | Thermal warning flag |
| otsd_i | input | 1 | Thermal shutdown flag |
| ovp_mode_i | input | 1 | Overvoltage policy |
| ocp_mode_i | input | 2 | Overcurrent policy |
| ilim_rpt_i | input | 1 | Current-limit reporting enable |
| spi_mode_i | input | 1 | Serial-error reporting enable |
| otw_mode_i | input | 1 | Thermal warning reporting enable |
| retry_cycles_i | input | RETRY_W | Overcurrent retry count |
| clr_flt_i | input | 1 | Clear-fault pulse |
| sleep_rst_i | input | 1 | Sleep-pin reset pulse |
| hiz_o | output | 1 | Bridge high-impedance enable |
| logic_dis_o | output | 1 | Logic disable |
| fault_no | output | 1 | Fault pin, active low |
| status_o | output | 9 | Sticky status bits |
| hs_off_o | output | N_PH | High-side current-limit gating |
| ls_off_o | output | N_PH | Low-side current-limit gating |

## Verification
Each fault class is driven on its own under every mode value, so policy decoding errors show up. The tested classes are: overvoltage on and off, all four overcurrent codes, and the reporting enables for current limit, serial error and thermal warning.

Every test first raises a flag and then drops it before clearing. This separates the live, auto-recovering bridge response from the sticky status and fault pin. Clears are also issued while a condition persists, to check that the bit is kept.

The retry test counts the exact number of high-impedance cycles. The current-limit test toggles the wrong side's gate input before the matching one, and watches a second phase, to show that release is tied to the right switch.

// File: rtl/fault_resp_pkg.sv
package fault_resp_pkg;
  localparam int unsigned ST_RST  = 0;
  localparam int unsigned ST_CPUV = 1;
  localparam int unsigned ST_OVP  = 2;
  localparam int unsigned ST_OCP  = 3;
  localparam int unsigned ST_ILIM = 4;
  localparam int unsigned ST_SPI  = 5;
  localparam int unsigned ST_OTP  = 6;
  localparam int unsigned ST_OTW  = 7;
  localparam int unsigned ST_OTSD = 8;
  localparam int unsigned N_STAT  = 9;

  // reset bit never reaches the fault pin
  localparam logic [N_STAT-1:0] RPT_MASK = {{(N_STAT-1){1'b1}}, 1'b0};

  typedef enum logic [1:0] {
    OCP_LATCH  = 2'b00,
    OCP_RETRY  = 2'b01,
    OCP_REPORT = 2'b10,
    OCP_OFF    = 2'b11
  } ocp_mode_e;
endpackage

// File: rtl/fault_resp_status.sv
module fault_resp_status #(
  parameter int unsigned N = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] q;

  for (genvar k = 0; k < N; k++) begin : g_bit
    // set dominates: a persisting condition survives a clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q[k] <= 1'b0;
      else         q[k] <= set_i[k] | (q[k] & ~clr_i);
    end
  end

  assign q_o = q;
endmodule

// File: rtl/fault_resp_retry.sv
module fault_resp_retry #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         flag_i,
  input  logic [W-1:0] load_i,
  output logic         hiz_o
);
  logic         hiz_q;
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hiz_q <= 1'b0;
      cnt_q <= '0;
    end else if (!en_i) begin
      hiz_q <= 1'b0;
      cnt_q <= '0;
    end else if (!hiz_q) begin
      if (flag_i) begin
        hiz_q <= 1'b1;
        cnt_q <= load_i;
      end
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end else if (flag_i) begin
      cnt_q <= load_i;
    end else begin
      hiz_q <= 1'b0;
    end
  end

  assign hiz_o = hiz_q;
endmodule

// File: rtl/fault_resp_ilim_gate.sv
module fault_resp_ilim_gate #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] ilim_i,
  input  logic [N-1:0] gate_i,
  output logic [N-1:0] off_o
);
  logic [N-1:0] off_q;
  logic [N-1:0] gate_q;

  for (genvar p = 0; p < N; p++) begin : g_sw
    logic rise;
    assign rise = gate_i[p] & ~gate_q[p];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        off_q[p]  <= 1'b0;
        gate_q[p] <= 1'b0;
      end else begin
        gate_q[p] <= gate_i[p];
        if (ilim_i[p])  off_q[p] <= 1'b1;
        else if (rise)  off_q[p] <= 1'b0;
      end
    end
  end

  assign off_o = off_q;
endmodule

// File: rtl/fault_resp_ctrl.sv
module fault_resp_ctrl
  import fault_resp_pkg::*;
#(
  parameter int unsigned N_PH    = 3,
  parameter int unsigned N_RAIL  = 3,
  parameter int unsigned RETRY_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_RAIL-1:0]  uv_i,
  input  logic               cpuv_i,
  input  logic               ovp_i,
  input  logic               ocp_i,
  input  logic [N_PH-1:0]    ilim_hs_i,
  input  logic [N_PH-1:0]    ilim_ls_i,
  input  logic [N_PH-1:0]    gate_hs_i,
  input  logic [N_PH-1:0]    gate_ls_i,
  input  logic               spi_err_i,
  input  logic               otp_err_i,
  input  logic               otw_i,
  input  logic               otsd_i,
  input  logic               ovp_mode_i,
  input  logic [1:0]         ocp_mode_i,
  input  logic               ilim_rpt_i,
  input  logic               spi_mode_i,
  input  logic               otw_mode_i,
  input  logic [RETRY_W-1:0] retry_cycles_i,
  input  logic               clr_flt_i,
  input  logic               sleep_rst_i,
  output logic               hiz_o,
  output logic               logic_dis_o,
  output logic               fault_no,
  output logic [N_STAT-1:0]  status_o,
  output logic [N_PH-1:0]    hs_off_o,
  output logic [N_PH-1:0]    ls_off_o
);
  ocp_mode_e         ocp_mode;
  logic              clr;
  logic [N_STAT-1:0] set_vec;
  logic [N_STAT-1:0] stat_q;
  logic              uv_q, cpuv_q, ovp_q, otsd_q, ocp_latch_q;
  logic              retry_hiz;

  assign ocp_mode = ocp_mode_e'(ocp_mode_i);
  assign clr      = clr_flt_i | sleep_rst_i;

  always_comb begin
    set_vec          = '0;
    set_vec[ST_RST]  = |uv_i;
    set_vec[ST_CPUV] = cpuv_i;
    set_vec[ST_OVP]  = ovp_i & ovp_mode_i;
    set_vec[ST_OCP]  = ocp_i & (ocp_mode != OCP_OFF);
    set_vec[ST_ILIM] = ilim_rpt_i & (|{ilim_hs_i, ilim_ls_i});
    set_vec[ST_SPI]  = spi_err_i & spi_mode_i;
    set_vec[ST_OTP]  = otp_err_i;
    set_vec[ST_OTW]  = otw_i & otw_mode_i;
    set_vec[ST_OTSD] = otsd_i;
  end

  fault_resp_status #(.N(N_STAT)) u_status (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_vec),
    .clr_i  (clr),
    .q_o    (stat_q)
  );

  // live copies for self-recovering faults
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uv_q        <= 1'b0;
      cpuv_q      <= 1'b0;
      ovp_q       <= 1'b0;
      otsd_q      <= 1'b0;
      ocp_latch_q <= 1'b0;
    end else begin
      uv_q        <= |uv_i;
      cpuv_q      <= cpuv_i;
      ovp_q       <= ovp_i & ovp_mode_i;
      otsd_q      <= otsd_i;
      ocp_latch_q <= (ocp_i & (ocp_mode == OCP_LATCH)) | (ocp_latch_q & ~(clr & ~ocp_i));
    end
  end

  fault_resp_retry #(.W(RETRY_W)) u_retry (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ocp_mode == OCP_RETRY),
    .flag_i (ocp_i),
    .load_i (retry_cycles_i),
    .hiz_o  (retry_hiz)
  );

  fault_resp_ilim_gate #(.N(N_PH)) u_ilim_hs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ilim_i (ilim_hs_i),
    .gate_i (gate_hs_i),
    .off_o  (hs_off_o)
  );

  fault_resp_ilim_gate #(.N(N_PH)) u_ilim_ls (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ilim_i (ilim_ls_i),
    .gate_i (gate_ls_i),
    .off_o  (ls_off_o)
  );

  assign hiz_o       = uv_q | cpuv_q | ovp_q | otsd_q | ocp_latch_q | retry_hiz | stat_q[ST_OTP];
  assign logic_dis_o = uv_q;
  assign fault_no    = ~|(stat_q & RPT_MASK);
  assign status_o    = stat_q;
endmodule

// File: rtl/fault_resp_ctrl_chk.sv
module fault_resp_ctrl_chk #(
  parameter int unsigned N_PH   = 3,
  parameter int unsigned N_RAIL = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_RAIL-1:0] uv_i,
  input logic              cpuv_i,
  input logic              ovp_i,
  input logic              ovp_mode_i,
  input logic              ocp_i,
  input logic [1:0]        ocp_mode_i,
  input logic              otsd_i,
  input logic [N_PH-1:0]   ilim_hs_i,
  input logic [N_PH-1:0]   ilim_ls_i,
  input logic              clr_flt_i,
  input logic              sleep_rst_i,
  input logic              hiz_o,
  input logic              logic_dis_o,
  input logic              fault_no,
  input logic [8:0]        status_o,
  input logic [N_PH-1:0]   hs_off_o,
  input logic [N_PH-1:0]   ls_off_o
);
  a_r1_uv_disables: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|uv_i) |=> (hiz_o && logic_dis_o));

  a_r2_cpuv_hiz_logic_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpuv_i && !(|uv_i)) |=> (hiz_o && !logic_dis_o && !fault_no));

  a_r3_ovp_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovp_i && ovp_mode_i) |=> (hiz_o && !fault_no));

  a_r4_ocp_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ocp_i && ocp_mode_i == 2'b00) |=> (hiz_o && !fault_no));

  a_r6_ocp_report: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ocp_i && ocp_mode_i == 2'b10) |=> !fault_no);

  a_r11_otsd_hiz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    otsd_i |=> (hiz_o && !fault_no));

  a_r12_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_flt_i && !sleep_rst_i) |=> ((status_o & $past(status_o)) == $past(status_o)));

  for (genvar p = 0; p < N_PH; p++) begin : g_ph
    a_r7_hs_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ilim_hs_i[p] |=> hs_off_o[p]);
    a_r7_ls_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ilim_ls_i[p] |=> ls_off_o[p]);
  end
endmodule

bind fault_resp_ctrl fault_resp_ctrl_chk #(.N_PH(N_PH), .N_RAIL(N_RAIL)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .uv_i        (uv_i),
  .cpuv_i      (cpuv_i),
  .ovp_i       (ovp_i),
  .ovp_mode_i  (ovp_mode_i),
  .ocp_i       (ocp_i),
  .ocp_mode_i  (ocp_mode_i),
  .otsd_i      (otsd_i),
  .ilim_hs_i   (ilim_hs_i),
  .ilim_ls_i   (ilim_ls_i),
  .clr_flt_i   (clr_flt_i),
  .sleep_rst_i (sleep_rst_i),
  .hiz_o       (hiz_o),
  .logic_dis_o (logic_dis_o),
  .fault_no    (fault_no),
  .status_o    (status_o),
  .hs_off_o    (hs_off_o),
  .ls_off_o    (ls_off_o)
);

// File: tb/fault_resp_ctrl_tb_top.sv
module fault_resp_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_PH       = 3;
  localparam int N_RAIL     = 3;
  localparam int RETRY_W    = 16;
  localparam int RETRY      = 5;

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic [N_RAIL-1:0]  uv_i = '0;
  logic               cpuv_i = 0, ovp_i = 0, ocp_i = 0;
  logic [N_PH-1:0]    ilim_hs_i = '0, ilim_ls_i = '0, gate_hs_i = '0, gate_ls_i = '0;
  logic               spi_err_i = 0, otp_err_i = 0, otw_i = 0, otsd_i = 0;
  logic               ovp_mode_i = 0;
  logic [1:0]         ocp_mode_i = 2'b00;
  logic               ilim_rpt_i = 0, spi_mode_i = 0, otw_mode_i = 0;
  logic [RETRY_W-1:0] retry_cycles_i = RETRY_W'(RETRY);
  logic               clr_flt_i = 0, sleep_rst_i = 0;
  logic               hiz_o, logic_dis_o, fault_no;
  logic [8:0]         status_o;
  logic [N_PH-1:0]    hs_off_o, ls_off_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fault_resp_ctrl #(.N_PH(N_PH), .N_RAIL(N_RAIL), .RETRY_W(RETRY_W)) dut_i (
    .clk_i, .rst_ni, .uv_i, .cpuv_i, .ovp_i, .ocp_i, .ilim_hs_i, .ilim_ls_i,
    .gate_hs_i, .gate_ls_i, .spi_err_i, .otp_err_i, .otw_i, .otsd_i,
    .ovp_mode_i, .ocp_mode_i, .ilim_rpt_i, .spi_mode_i, .otw_mode_i,
    .retry_cycles_i, .clr_flt_i, .sleep_rst_i, .hiz_o, .logic_dis_o,
    .fault_no, .status_o, .hs_off_o, .ls_off_o
  );

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_clr(input bit use_sleep);
    if (use_sleep) sleep_rst_i = 1'b1;
    else           clr_flt_i   = 1'b1;
    tick();
    clr_flt_i   = 1'b0;
    sleep_rst_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R13 reset fault_no", 32'(fault_no), 1);
    chk("R1 reset hiz", 32'(hiz_o), 0);
    chk("R1 reset logic_dis", 32'(logic_dis_o), 0);
    chk("R12 reset status", 32'(status_o), 0);
    chk("R7 reset gating", 32'({hs_off_o, ls_off_o}), 0);
  endtask

  task automatic t_uv();
    uv_i = 3'b010; tick();
    chk("R1 uv hiz", 32'(hiz_o), 1);
    chk("R1 uv logic_dis", 32'(logic_dis_o), 1);
    chk("R1 uv status", 32'(status_o), 32'h001);
    chk("R1 uv no fault pin", 32'(fault_no), 1);
    uv_i = '0; tick();
    chk("R1 uv recover hiz", 32'({hiz_o, logic_dis_o}), 0);
    chk("R12 uv sticky", 32'(status_o), 32'h001);
    pulse_clr(1'b1);
    chk("R12 uv sleep clear", 32'(status_o), 0);
  endtask

  task automatic t_cpuv();
    cpuv_i = 1'b1; tick();
    chk("R2 cpuv hiz", 32'(hiz_o), 1);
    chk("R2 cpuv logic on", 32'(logic_dis_o), 0);
    chk("R2 cpuv pin", 32'(fault_no), 0);
    chk("R13 cpuv status", 32'(status_o), 32'h002);
    cpuv_i = 1'b0; tick();
    chk("R2 cpuv recover", 32'(hiz_o), 0);
    chk("R13 cpuv pin sticky", 32'(fault_no), 0);
    pulse_clr(1'b0);
    chk("R12 cpuv clear pin", 32'(fault_no), 1);
  endtask

  task automatic t_ovp();
    ovp_mode_i = 1'b0; ovp_i = 1'b1; tick();
    chk("R3 ovp off", 32'({hiz_o, fault_no, status_o}), 32'h200);
    ovp_mode_i = 1'b1; tick();
    chk("R3 ovp on hiz", 32'(hiz_o), 1);
    chk("R3 ovp on status", 32'({fault_no, status_o}), 32'h004);
    ovp_i = 1'b0; tick();
    chk("R3 ovp recover", 32'(hiz_o), 0);
    pulse_clr(1'b0);
    chk("R3 ovp cleared", 32'(status_o), 0);
    ovp_mode_i = 1'b0;
  endtask

  task automatic t_ocp_latch();
    ocp_mode_i = 2'b00; ocp_i = 1'b1; tick();
    chk("R4 ocp hiz", 32'(hiz_o), 1);
    ocp_i = 1'b0; tick(); tick();
    chk("R4 ocp latched", 32'({hiz_o, fault_no}), 32'h2);
    ocp_i = 1'b1; pulse_clr(1'b0);
    chk("R12 ocp clear while present hiz", 32'(hiz_o), 1);
    chk("R12 ocp clear while present status", 32'(status_o), 32'h008);
    ocp_i = 1'b0; tick();
    pulse_clr(1'b0);
    chk("R4 ocp released", 32'({hiz_o, fault_no, status_o}), 32'h200);
  endtask

  task automatic t_ocp_retry();
    ocp_mode_i = 2'b01; ocp_i = 1'b1; tick();
    chk("R5 retry hiz start", 32'(hiz_o), 1);
    ocp_i = 1'b0;
    for (int i = 0; i < RETRY; i++) begin
      tick();
      chk("R5 retry hiz hold", 32'(hiz_o), 1);
    end
    tick();
    chk("R5 retry release", 32'(hiz_o), 0);
    chk("R5 retry status sticky", 32'({fault_no, status_o}), 32'h008);
    pulse_clr(1'b0);
    chk("R5 retry cleared", 32'(status_o), 0);
  endtask

  task automatic t_ocp_report_off();
    ocp_mode_i = 2'b10; ocp_i = 1'b1; tick();
    chk("R6 report hiz", 32'(hiz_o), 0);
    chk("R6 report pin", 32'({fault_no, status_o}), 32'h008);
    ocp_i = 1'b0; tick();
    pulse_clr(1'b0);
    ocp_mode_i = 2'b11; ocp_i = 1'b1; tick(); tick();
    chk("R6 off no effect", 32'({hiz_o, fault_no, status_o}), 32'h200);
    ocp_i = 1'b0; ocp_mode_i = 2'b00; tick();
  endtask

  task automatic t_ilim();
    ilim_rpt_i = 1'b0; ilim_hs_i = 3'b001; tick();
    chk("R7 hs gated", 32'(hs_off_o), 32'h1);
    chk("R7 ls untouched", 32'(ls_off_o), 0);
    chk("R8 no report", 32'({fault_no, status_o}), 32'h200);
    ilim_hs_i = '0; tick();
    chk("R7 hs holds", 32'(hs_off_o), 32'h1);
    gate_ls_i = 3'b001; tick();
    chk("R7 wrong side edge", 32'(hs_off_o), 32'h1);
    gate_hs_i = 3'b100; tick();
    chk("R7 wrong phase edge", 32'(hs_off_o), 32'h1);
    gate_hs_i = 3'b101; tick();
    chk("R7 hs released", 32'(hs_off_o), 0);
    ilim_rpt_i = 1'b1; ilim_ls_i = 3'b001; tick();
    chk("R7 ls gated", 32'(ls_off_o), 32'h1);
    chk("R8 report", 32'({fault_no, status_o}), 32'h010);
    ilim_ls_i = '0; gate_ls_i = '0; tick();
    chk("R7 ls hold on fall", 32'(ls_off_o), 32'h1);
    gate_ls_i = 3'b001; tick();
    chk("R7 ls released", 32'(ls_off_o), 0);
    pulse_clr(1'b0);
    chk("R8 cleared", 32'(status_o), 0);
    gate_hs_i = '0; gate_ls_i = '0; ilim_rpt_i = 1'b0; tick();
  endtask

  task automatic t_spi();
    spi_mode_i = 1'b0; spi_err_i = 1'b1; tick();
    chk("R9 spi ignored", 32'({fault_no, status_o}), 32'h200);
    spi_mode_i = 1'b1; tick();
    chk("R9 spi report", 32'({hiz_o, fault_no, status_o}), 32'h020);
    spi_err_i = 1'b0; tick();
    chk("R9 spi sticky", 32'(status_o), 32'h020);
    pulse_clr(1'b1);
    chk("R9 spi cleared", 32'(fault_no), 1);
    spi_mode_i = 1'b0;
  endtask

  task automatic t_otp();
    otp_err_i = 1'b1; tick();
    chk("R10 otp hiz", 32'({hiz_o, fault_no}), 32'h2);
    otp_err_i = 1'b0; tick(); tick();
    chk("R10 otp latched", 32'(hiz_o), 1);
    pulse_clr(1'b0);
    chk("R10 otp released", 32'({hiz_o, fault_no, status_o}), 32'h200);
  endtask

  task automatic t_thermal();
    otw_mode_i = 1'b0; otw_i = 1'b1; tick();
    chk("R11 otw ignored", 32'({hiz_o, fault_no, status_o}), 32'h200);
    otw_mode_i = 1'b1; tick();
    chk("R11 otw report", 32'({hiz_o, fault_no, status_o}), 32'h080);
    otw_i = 1'b0; otsd_i = 1'b1; tick();
    chk("R11 otsd hiz", 32'(hiz_o), 1);
    chk("R13 two bits", 32'(status_o), 32'h180);
    pulse_clr(1'b0);
    chk("R12 partial clear", 32'(status_o), 32'h100);
    otsd_i = 1'b0; tick();
    chk("R11 otsd recover", 32'(hiz_o), 0);
    pulse_clr(1'b0);
    chk("R13 all clear pin", 32'({fault_no, status_o}), 32'h200);
    otw_mode_i = 1'b0;
  endtask

  initial begin
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_uv();
    t_cpuv();
    t_ovp();
    t_ocp_latch();
    t_ocp_retry();
    t_ocp_report_off();
    t_ilim();
    t_spi();
    t_otp();
    t_thermal();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule